// File: doc/BRIEF.md
# Fetch Address Remap Unit

This block sits on an instruction-fetch path and rewrites fetch addresses that fall inside one of four programmable windows. Each window is held in its own configuration word. That word sets whether the window is active, its size, the address bits that locate it, the target it maps onto, and the master port and burst kind that matching traffic takes. A fetch that lands in an active window leaves with its upper bits replaced by the window's target and with its offset inside the window unchanged. A fetch that lands in no window leaves untouched, on the default port and with the default burst kind.

The window size is a power of two from 2 MB to 128 MB. It is set by a 3-bit code, and the code sets how many of the locating and target bits take part. Configuration words are written one at a time through a simple write strobe with an index. A write is refused while the downstream cache is enabled. A write is also refused when it would alter a window that is already active, unless it only switches that window off. Translation is purely combinational. A hit flag and the winning window index come out alongside the result so that the path can be observed.

Top module: `addr_remap_unit`

## Requirements
- R1: After reset all four configuration words read 0, so every window is inactive and its size code is 0 (2 MB).
- R2: A configuration word has this layout: bit 0 active, bits 3:1 size code, bit 4 port select, bit 5 burst kind, bits 15:8 locating field, bits 26:16 target field. Size code c gives a window of 2 MB << c for c in 0..6, and code 7 acts as 128 MB. Port select 0 is the default port. Burst kind 1 means incrementing and 0 means wrapping. Every other bit reads 0. When the cache is disabled and the window is inactive, a write stores all defined fields. The stored word can be read back on `cfg_rdata_o` for the index on `cfg_idx_i` from the cycle after the write edge.
- R3: While `cache_en_i` is 1, every configuration write is ignored and no field of any word changes.
- R4: While a window is active, a write whose bit 0 is 1 is ignored. A write whose bit 0 is 0 clears only the active bit and keeps all other fields.
- R5: With effective size code s, an active window matches a fetch address when address bits 28:(21+s) equal locating-field bits 7:s. Address bits 31:29 and locating-field bits below s take no part in the compare.
- R6: On a match, output bits 31:(21+s) take target-field bits 10:s and output bits (20+s):0 take the input address bits. `port_sel_o` and `burst_incr_o` take the window's bits 4 and 5, `hit_o` is 1 and `hit_region_o` gives the window index.
- R7: With no match, `xlat_addr_o` equals `fetch_addr_i`, and `port_sel_o`, `burst_incr_o`, `hit_o` and `hit_region_o` are all 0.
- R8: When several active windows match, the one with the lowest index decides all outputs.
- R9: The outputs follow `fetch_addr_i` in the same cycle with no register on the way. A configuration change takes effect from the cycle after its write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cache_en_i | input | 1 | Cache enabled; blocks configuration writes |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | 2 | Window index for write and readback |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration word of the indexed window |
| fetch_addr_i | input | 32 | Incoming fetch address |
| xlat_addr_o | output | 32 | Translated address |
| port_sel_o | output | 1 | Selected master port (0 default) |
| burst_incr_o | output | 1 | Burst kind: 1 incrementing, 0 wrapping |
| hit_o | output | 1 | Some active window matched |
| hit_region_o | output | 2 | Index of the winning window |

## Verification
The clocked assertions assume that every input is a known value when it is sampled at the rising edge and that it is held steady around that edge. The write-refusal checks also assume that a write strobe and its data are presented together in one cycle. The stimulus meets these assumptions by changing every input only on the falling edge, by keeping `cfg_idx_i` within the four windows, and by driving whole-word writes. Fetch addresses are steered onto the programmed locating fields often enough that overlaps, the oversize code 7, and writes made while the cache is on or the window is active all arise among the directed and random cycles.

// File: rtl/remap_pkg.sv
package remap_pkg;

   // Field positions inside one window configuration word. Neighbouring
   // logic decodes these, so they are fixed here once.
   localparam int unsigned FLD_EN    = 0;
   localparam int unsigned FLD_SIZE  = 1;
   localparam int unsigned FLD_PORT  = 4;
   localparam int unsigned FLD_BURST = 5;
   localparam int unsigned FLD_BASE  = 8;
   localparam int unsigned FLD_REMAP = 16;

   // Attributes that travel with a matched access.
   typedef struct packed {
      logic port;
      logic incr;
   } rgn_attr_t;

endpackage

// File: rtl/remap_region_reg.sv
module remap_region_reg
   import remap_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned SIZE_W  = 3,
   parameter int unsigned BASE_W  = 8,
   parameter int unsigned REMAP_W = 11
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cache_en_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] q_o
);

   function automatic logic [DATA_W-1:0] defined_bits();
      logic [DATA_W-1:0] m;
      m = '0;
      m[FLD_EN]    = 1'b1;
      m[FLD_PORT]  = 1'b1;
      m[FLD_BURST] = 1'b1;
      for (int i = 0; i < int'(SIZE_W); i++)  m[FLD_SIZE + i]  = 1'b1;
      for (int i = 0; i < int'(BASE_W); i++)  m[FLD_BASE + i]  = 1'b1;
      for (int i = 0; i < int'(REMAP_W); i++) m[FLD_REMAP + i] = 1'b1;
      return m;
   endfunction

   localparam logic [DATA_W-1:0] WMASK = defined_bits();

   logic [DATA_W-1:0] q_r;
   logic              accept_full;
   logic              accept_clear;

   always_comb begin
      accept_full  = wr_i && !cache_en_i && !q_r[FLD_EN];
      accept_clear = wr_i && !cache_en_i &&  q_r[FLD_EN] && !wdata_i[FLD_EN];
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         q_r <= '0;
      end else if (accept_full) begin
         q_r <= wdata_i & WMASK;
      end else if (accept_clear) begin
         q_r[FLD_EN] <= 1'b0;
      end
   end

   assign q_o = q_r;

   // A write while the cache is on leaves the word untouched.
   assert_cache_lock_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && cache_en_i) |=> $stable(q_o));

   // An active window refuses a write that keeps it active.
   assert_active_lock_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && q_o[FLD_EN] && wdata_i[FLD_EN]) |=> $stable(q_o));

   // Switching an active window off keeps every other field.
   assert_clear_keeps_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !cache_en_i && q_o[FLD_EN] && !wdata_i[FLD_EN])
      |=> (!q_o[FLD_EN] && (q_o[DATA_W-1:1] == $past(q_o[DATA_W-1:1]))));

endmodule

// File: rtl/remap_region_match.sv
module remap_region_match
   import remap_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned REGION_LSB = 21,
   parameter int unsigned SIZE_W     = 3,
   parameter int unsigned BASE_W     = 8,
   parameter int unsigned REMAP_W    = 11,
   parameter int          MAX_CODE   = 6
) (
   input  logic [DATA_W-1:0]  cfg_i,
   input  logic [ADDR_W-1:0]  addr_i,
   output logic               hit_o,
   output logic [REMAP_W-1:0] hi_o,
   output rgn_attr_t          attr_o
);

   logic [SIZE_W-1:0]  code;
   int                 eff;
   logic [BASE_W-1:0]  base_fld;
   logic [REMAP_W-1:0] remap_fld;
   logic [BASE_W-1:0]  cmp_mask;
   logic [REMAP_W-1:0] rep_mask;
   logic [BASE_W-1:0]  addr_cmp;
   logic [REMAP_W-1:0] addr_hi;
   logic               unused_bits;

   assign unused_bits = ^{cfg_i, addr_i};

   always_comb begin
      code      = cfg_i[FLD_SIZE +: SIZE_W];
      eff       = (int'(code) > MAX_CODE) ? MAX_CODE : int'(code);
      base_fld  = cfg_i[FLD_BASE +: BASE_W];
      remap_fld = cfg_i[FLD_REMAP +: REMAP_W];
      addr_cmp  = addr_i[REGION_LSB +: BASE_W];
      addr_hi   = addr_i[REGION_LSB +: REMAP_W];
      for (int i = 0; i < int'(BASE_W); i++)  cmp_mask[i] = (i >= eff);
      for (int i = 0; i < int'(REMAP_W); i++) rep_mask[i] = (i >= eff);
      hit_o       = cfg_i[FLD_EN] && (((addr_cmp ^ base_fld) & cmp_mask) == '0);
      hi_o        = (remap_fld & rep_mask) | (addr_hi & ~rep_mask);
      attr_o.port = cfg_i[FLD_PORT];
      attr_o.incr = cfg_i[FLD_BURST];
   end

endmodule

// File: rtl/remap_prio_sel.sv
module remap_prio_sel #(
   parameter int unsigned N_IN  = 4,
   parameter int unsigned IDX_W = 2,
   parameter int unsigned PAY_W = 13
) (
   input  logic [N_IN-1:0]            hit_i,
   input  logic [N_IN-1:0][PAY_W-1:0] pay_i,
   output logic                       any_o,
   output logic [IDX_W-1:0]           idx_o,
   output logic [PAY_W-1:0]           pay_o
);

   // Scan from the top down so that the lowest index is written last.
   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      pay_o = '0;
      for (int i = int'(N_IN) - 1; i >= 0; i--) begin
         if (hit_i[i]) begin
            any_o = 1'b1;
            idx_o = IDX_W'(i);
            pay_o = pay_i[i];
         end
      end
   end

endmodule

// File: rtl/addr_remap_unit.sv
module addr_remap_unit
   import remap_pkg::*;
#(
   parameter int unsigned N_REGIONS  = 4,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned REGION_LSB = 21,
   parameter int unsigned SIZE_W     = 3,
   parameter int unsigned N_SIZES    = 7,
   parameter int unsigned BASE_W     = 8,
   parameter int unsigned REMAP_W    = 11,
   parameter logic        DEF_PORT   = 1'b0,
   parameter logic        DEF_INCR   = 1'b0,
   localparam int unsigned IDX_W     = $clog2(N_REGIONS)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cache_en_i,
   input  logic              cfg_we_i,
   input  logic [IDX_W-1:0]  cfg_idx_i,
   input  logic [DATA_W-1:0] cfg_wdata_i,
   output logic [DATA_W-1:0] cfg_rdata_o,
   input  logic [ADDR_W-1:0] fetch_addr_i,
   output logic [ADDR_W-1:0] xlat_addr_o,
   output logic              port_sel_o,
   output logic              burst_incr_o,
   output logic              hit_o,
   output logic [IDX_W-1:0]  hit_region_o
);

   localparam int          MAX_CODE = int'(N_SIZES) - 1;
   localparam int unsigned PAY_W    = REMAP_W + 2;

   // Elaboration-time parameter checks.
   if (ADDR_W != REGION_LSB + REMAP_W) begin : g_bad_addr
      $error("ADDR_W must equal REGION_LSB + REMAP_W");
   end
   if (BASE_W <= MAX_CODE || REMAP_W <= MAX_CODE) begin : g_bad_fields
      $error("base and target fields must keep at least one bit at the largest size");
   end
   if ((1 << SIZE_W) < N_SIZES) begin : g_bad_size_w
      $error("SIZE_W too narrow for N_SIZES");
   end
   if (N_REGIONS < 2 || (1 << IDX_W) != N_REGIONS) begin : g_bad_count
      $error("N_REGIONS must be a power of two of at least 2");
   end
   if (FLD_SIZE + SIZE_W > FLD_PORT || FLD_BASE + BASE_W > FLD_REMAP
       || FLD_REMAP + REMAP_W > DATA_W) begin : g_bad_layout
      $error("configuration fields overlap or overflow the word");
   end

   logic [DATA_W-1:0]                 rgn_q   [N_REGIONS];
   logic [N_REGIONS-1:0]              hit_vec;
   logic [N_REGIONS-1:0][PAY_W-1:0]   pay_vec;
   logic                              sel_any;
   logic [IDX_W-1:0]                  sel_idx;
   logic [PAY_W-1:0]                  sel_pay;

   for (genvar r = 0; r < int'(N_REGIONS); r++) begin : g_rgn
      logic [REMAP_W-1:0] hi;
      rgn_attr_t          attr;

      remap_region_reg #(
         .DATA_W (DATA_W),
         .SIZE_W (SIZE_W),
         .BASE_W (BASE_W),
         .REMAP_W(REMAP_W)
      ) u_reg (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .cache_en_i(cache_en_i),
         .wr_i      (cfg_we_i && (cfg_idx_i == IDX_W'(r))),
         .wdata_i   (cfg_wdata_i),
         .q_o       (rgn_q[r])
      );

      remap_region_match #(
         .DATA_W    (DATA_W),
         .ADDR_W    (ADDR_W),
         .REGION_LSB(REGION_LSB),
         .SIZE_W    (SIZE_W),
         .BASE_W    (BASE_W),
         .REMAP_W   (REMAP_W),
         .MAX_CODE  (MAX_CODE)
      ) u_match (
         .cfg_i (rgn_q[r]),
         .addr_i(fetch_addr_i),
         .hit_o (hit_vec[r]),
         .hi_o  (hi),
         .attr_o(attr)
      );

      assign pay_vec[r] = {hi, attr.port, attr.incr};

      // Any matching window forces a hit by itself or a lower index.
      assert_lowest_wins_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         hit_vec[r] |-> (hit_o && (hit_region_o <= IDX_W'(r))));
   end

   remap_prio_sel #(
      .N_IN (N_REGIONS),
      .IDX_W(IDX_W),
      .PAY_W(PAY_W)
   ) u_sel (
      .hit_i(hit_vec),
      .pay_i(pay_vec),
      .any_o(sel_any),
      .idx_o(sel_idx),
      .pay_o(sel_pay)
   );

   always_comb begin
      cfg_rdata_o  = rgn_q[cfg_idx_i];
      hit_o        = sel_any;
      hit_region_o = sel_idx;
      if (sel_any) begin
         xlat_addr_o  = {sel_pay[PAY_W-1:2], fetch_addr_i[REGION_LSB-1:0]};
         port_sel_o   = sel_pay[1];
         burst_incr_o = sel_pay[0];
      end else begin
         xlat_addr_o  = fetch_addr_i;
         port_sel_o   = DEF_PORT;
         burst_incr_o = DEF_INCR;
      end
   end

   // Unmatched fetches leave unchanged with default attributes.
   assert_passthru_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hit_o |-> ((xlat_addr_o == fetch_addr_i) && (port_sel_o == DEF_PORT)
                  && (burst_incr_o == DEF_INCR) && (hit_region_o == '0)));

   // The 2 MB offset is never rewritten.
   assert_offset_kept_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_o |-> (xlat_addr_o[REGION_LSB-1:0] == fetch_addr_i[REGION_LSB-1:0]));

   // Only an active window can win.
   assert_hit_active_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_o |-> rgn_q[hit_region_o][FLD_EN]);

endmodule

// File: tb/addr_remap_unit_tb_top.sv
`timescale 1ns/1ps
module addr_remap_unit_tb_top;

   localparam bit [31:0] WMASK = 32'h07FF_FF3F;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cache_en;
   logic        cfg_we;
   logic [1:0]  cfg_idx;
   logic [31:0] cfg_wdata;
   logic [31:0] cfg_rdata;
   logic [31:0] fetch_addr;
   logic [31:0] xlat_addr;
   logic        port_sel;
   logic        burst_incr;
   logic        hit;
   logic [1:0]  hit_region;

   always #10 clk = ~clk;

   addr_remap_unit dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .cache_en_i  (cache_en),
      .cfg_we_i    (cfg_we),
      .cfg_idx_i   (cfg_idx),
      .cfg_wdata_i (cfg_wdata),
      .cfg_rdata_o (cfg_rdata),
      .fetch_addr_i(fetch_addr),
      .xlat_addr_o (xlat_addr),
      .port_sel_o  (port_sel),
      .burst_incr_o(burst_incr),
      .hit_o       (hit),
      .hit_region_o(hit_region)
   );

   int    n_checks = 0;
   int    n_fail   = 0;
   bit    done     = 0;
   bit [31:0] m_reg [4];
   string     rd_tag [4];

   // Behavioural model of the configuration words, updated at each edge.
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) begin
            m_reg[i]  = 32'h0;
            rd_tag[i] = "R1";
         end
      end else if (cfg_we) begin
         if (cache_en) begin
            rd_tag[cfg_idx] = "R3";
         end else if (m_reg[cfg_idx][0]) begin
            rd_tag[cfg_idx] = "R4";
            if (!cfg_wdata[0]) m_reg[cfg_idx][0] = 1'b0;
         end else begin
            rd_tag[cfg_idx] = "R2";
            m_reg[cfg_idx]  = cfg_wdata & WMASK;
         end
      end
   end

   function automatic void model_out(input bit [31:0] a, output bit [31:0] xa,
                                     output bit p, output bit b, output bit h,
                                     output int ri, output int nh);
      xa = a; p = 0; b = 0; h = 0; ri = 0; nh = 0;
      for (int r = 0; r < 4; r++) begin
         bit [31:0] w;
         int        s;
         bit [31:0] rm32;
         bit [7:0]  base;
         bit [7:0]  acmp;
         w = m_reg[r];
         if (!w[0]) continue;
         s    = int'(w[3:1]);
         if (s > 6) s = 6;
         base = w[15:8];
         acmp = a[28:21];
         if ((acmp >> s) == (base >> s)) begin
            nh++;
            if (!h) begin
               h    = 1;
               ri   = r;
               rm32 = {21'h0, w[26:16]};
               xa   = ((rm32 >> s) << (21 + s)) | (a & ((32'h1 << (21 + s)) - 1));
               p    = w[4];
               b    = w[5];
            end
         end
      end
   endfunction

   task automatic check_now();
      bit [31:0] xa;
      bit        p, b, h;
      int        ri, nh;
      string     tag;
      n_checks++;
      if (cfg_rdata !== m_reg[cfg_idx]) begin
         n_fail++;
         $display("FAIL %s readback idx %0d: actual %h expected %h",
                  rd_tag[cfg_idx], cfg_idx, cfg_rdata, m_reg[cfg_idx]);
      end
      model_out(fetch_addr, xa, p, b, h, ri, nh);
      if (nh > 1)  tag = "R8";
      else if (h)  tag = "R5 R6 R9";
      else         tag = "R7";
      n_checks++;
      if (xlat_addr !== xa || port_sel !== p || burst_incr !== b
          || hit !== h || hit_region !== 2'(ri)) begin
         n_fail++;
         $display("FAIL %s addr %h: actual %h/%b/%b/%b/%0d expected %h/%b/%b/%b/%0d",
                  tag, fetch_addr, xlat_addr, port_sel, burst_incr, hit, hit_region,
                  xa, p, b, h, ri);
      end
   endtask

   task automatic step(input bit we, input bit ce, input bit [1:0] idx,
                       input bit [31:0] wd, input bit [31:0] a);
      @(negedge clk);
      check_now();
      cfg_we     = we;
      cache_en   = ce;
      cfg_idx    = idx;
      cfg_wdata  = wd;
      fetch_addr = a;
   endtask

   function automatic bit [31:0] word(input bit en, input int sz, input bit p,
                                      input bit b, input bit [7:0] base,
                                      input bit [10:0] rm);
      return {5'h0, rm, base, 2'b00, b, p, 3'(sz), en};
   endfunction

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
      end
   end

   initial begin
      rst_n = 0; cache_en = 0; cfg_we = 0; cfg_idx = 0; cfg_wdata = 0;
      fetch_addr = 32'h0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      // R1: reset state of every word, fetches pass through (R7)
      for (int i = 0; i < 4; i++) step(0, 0, 2'(i), 0, 32'h0200_1234 + i);
      // R2: full write on an inactive window, reserved bits drop
      step(1, 0, 0, 32'hFFFF_FFFE, 32'h1);
      step(0, 0, 0, 0, 32'h0200_0000);
      // Program four windows
      step(1, 0, 0, word(1, 0, 1, 1, 8'h10, 11'h400), 32'h0);
      step(1, 0, 1, word(1, 3, 0, 1, 8'h20, 11'h123), 32'h0);
      step(1, 0, 2, word(1, 6, 1, 0, 8'hC0, 11'h1A0), 32'h0);
      step(1, 0, 3, word(1, 5, 1, 1, 8'h20, 11'h7E0), 32'h0);
      // R5/R6/R8 directed fetches
      step(0, 0, 0, 0, 32'h0200_1234);
      step(0, 0, 1, 0, 32'h8200_1234);
      step(0, 0, 2, 0, 32'h0412_3456);
      step(0, 0, 3, 0, 32'h0600_00FF);
      step(0, 0, 0, 0, 32'h03E0_0000);
      step(0, 0, 0, 0, 32'h1FFF_FFFF);
      // R3: write during cache enable ignored
      step(1, 1, 1, 32'h0, 32'h0412_3456);
      step(0, 0, 1, 0, 32'h0412_3456);
      // R4: write keeping active ignored; clearing keeps fields
      step(1, 0, 0, word(1, 2, 0, 0, 8'h55, 11'h055), 32'h0200_0010);
      step(1, 0, 3, 32'h0, 32'h0600_0000);
      step(0, 0, 3, 0, 32'h0600_0000);
      step(1, 0, 3, word(1, 7, 0, 1, 8'h30, 11'h2AA), 32'h0600_0000);
      step(0, 0, 3, 0, 32'h0600_0004);
      // Random mix
      for (int k = 0; k < 4000; k++) begin
         bit [31:0] a;
         bit [1:0]  r;
         a = $urandom;
         r = 2'($urandom);
         if ($urandom % 2 == 0) a[28:21] = m_reg[r][15:8] ^ 8'(($urandom % 4 == 0) ? (1 << ($urandom % 8)) : 0);
         step(($urandom % 8) == 0, ($urandom % 4) == 0, 2'($urandom), $urandom, a);
      end
      step(0, 0, 0, 0, 32'h0);
      done = 1;
      report();
   end

endmodule